// File: doc/BRIEF.md
# SPI Bus Snoop Encoder

This block listens to an SPI bus without ever driving it and turns what it sees into a byte stream for a host link. The clock, chip select and both data lines are oversampled by the system clock. Each completed transfer byte is reported as an escaped master-out value followed by the slave-out value in parentheses. Chip-select transitions are reported as bracket tokens. The host starts a session with one of three filter commands. Any later host byte ends the session, and the block answers with an acknowledge token.

Bytes are assembled with the clock polarity, capture edge and slave-out sample point that are configured for the bus. The slave-out sample point selects either the master-out capture edge or the opposite clock edge. All encoded tokens pass through an output FIFO that has a ready/valid drain. If the FIFO is full, further tokens are discarded and a sticky overflow flag is set. The system clock must run at four or more times the bus clock.

Top module: `spi_snoop_encoder`

## Requirements
- R1: A session starts only when `arm_i` pulses while idle with `arm_cmd_i` equal to 0x0D, 0x0E or 0x0F. Any other command value leaves the block idle, and no tokens are produced.
- R2: The filter is set by the starting command. 0x0D captures in every chip-select state. 0x0E captures only while `cs_n_i` is low. 0x0F captures only while `cs_n_i` is high.
- R3: During a session, a falling edge of `cs_n_i` emits 0x5B ('['). A rising edge of `cs_n_i` emits 0x5D (']'). Both are emitted in every filter mode.
- R4: Each captured byte is assembled MSB first. Its master-out value is emitted as 0x5C (escape) followed by the raw value.
- R5: The slave-out value of the same byte follows as 0x28, the value, 0x29. The five tokens of one byte appear in that order.
- R6: `cpol_i` gives the idle clock level (0 low, 1 high). `cke_i`=1 captures master-out on the idle-to-active edge. `cke_i`=0 captures it on the active-to-idle edge.
- R7: `smp_i`=0 samples slave-out on the master-out capture edge. `smp_i`=1 samples it on the opposite clock edge. A byte completes when both lines have 8 bits.
- R8: A partially assembled byte is discarded at any chip-select edge and never reported.
- R9: A `host_rx_valid_i` pulse during a session ends it. The token 0x01 is emitted after every token already pending. Bus activity after that produces nothing.
- R10: If the FIFO is full, a new token is dropped and `ovf_o` sets. `ovf_o` stays set until the next accepted start. While `tok_ready_i` is low, `tok_valid_o` and `tok_data_o` hold.
- R11: After reset the block is idle, `tok_valid_o` is 0 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Observed bus clock |
| cs_n_i | input | 1 | Observed chip select, active low |
| mosi_i | input | 1 | Observed master-out data |
| miso_i | input | 1 | Observed slave-out data |
| cpol_i | input | 1 | Idle clock level |
| cke_i | input | 1 | Capture edge select |
| smp_i | input | 1 | Slave-out sample point select |
| arm_i | input | 1 | Start-command strobe |
| arm_cmd_i | input | 8 | Start command value |
| host_rx_valid_i | input | 1 | Host byte received strobe, ends a session |
| tok_valid_o | output | 1 | Encoded token available |
| tok_data_o | output | 8 | Encoded token |
| tok_ready_i | input | 1 | Token consumer ready |
| ovf_o | output | 1 | Sticky token-drop flag |

## Verification
The bench targets four kinds of mistake. It changes slave-out between the two clock edges in sample-at-end mode, so a design that ignores `smp_i` reports a byte shifted by one bit. It ends a chip-select window after five bits, so a design that keeps partial bits reports a byte merged across two windows. It runs each filter mode with traffic on both chip-select levels, and it fills the FIFO with its consumer stalled. A design that drops the wrong token or fails to latch the flag shows a wrong drained count, a wrong first token or a clear `ovf_o`.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      FILT_ANY  = 2'd0,
      FILT_LOW  = 2'd1,
      FILT_HIGH = 2'd2
   } filt_e;

   localparam logic [7:0] CMD_ANY   = 8'h0D;
   localparam logic [7:0] CMD_LOW   = 8'h0E;
   localparam logic [7:0] CMD_HIGH  = 8'h0F;

   localparam logic [7:0] TOK_OPEN  = 8'h5B;
   localparam logic [7:0] TOK_CLOSE = 8'h5D;
   localparam logic [7:0] TOK_ESC   = 8'h5C;
   localparam logic [7:0] TOK_LPAR  = 8'h28;
   localparam logic [7:0] TOK_RPAR  = 8'h29;
   localparam logic [7:0] TOK_ACK   = 8'h01;

   function automatic logic cmd_ok(input logic [7:0] c);
      return (c == CMD_ANY) || (c == CMD_LOW) || (c == CMD_HIGH);
   endfunction

   function automatic filt_e cmd_filt(input logic [7:0] c);
      case (c)
         CMD_LOW:  return FILT_LOW;
         CMD_HIGH: return FILT_HIGH;
         default:  return FILT_ANY;
      endcase
   endfunction
endpackage

// File: rtl/snoop_sync.sv
module snoop_sync #(
   parameter int         W       = 4,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("snoop_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= RST_VAL;
         else if (i == 0) stage_q[i] <= d;
         else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/snoop_capture.sv
module snoop_capture #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic              sck,
   input  logic              mosi,
   input  logic              miso,
   input  logic              cpol,
   input  logic              cke,
   input  logic              smp,
   output logic              done,
   output logic [DATA_W-1:0] mosi_byte,
   output logic [DATA_W-1:0] miso_byte
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

   logic              sck_d;
   logic [CNT_W-1:0]  mo_cnt, mi_cnt;
   logic [DATA_W-1:0] mo_sh, mi_sh;
   logic rise, fall, lead, trail, cap_e, miso_e, both_full;

   assign rise      = sck & ~sck_d;
   assign fall      = ~sck & sck_d;
   assign lead      = cpol ? fall : rise;
   assign trail     = cpol ? rise : fall;
   assign cap_e     = cke ? lead : trail;
   assign miso_e    = smp ? (cke ? trail : lead) : cap_e;
   assign both_full = (mo_cnt == FULL) && (mi_cnt == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d     <= 1'b0;
         mo_cnt    <= '0;
         mi_cnt    <= '0;
         mo_sh     <= '0;
         mi_sh     <= '0;
         done      <= 1'b0;
         mosi_byte <= '0;
         miso_byte <= '0;
      end else begin
         sck_d <= sck;
         done  <= 1'b0;
         if (clr) begin
            mo_cnt <= '0;
            mi_cnt <= '0;
         end else if (both_full) begin
            done      <= 1'b1;
            mosi_byte <= mo_sh;
            miso_byte <= mi_sh;
            mo_cnt    <= '0;
            mi_cnt    <= '0;
         end else if (en) begin
            if (cap_e && mo_cnt != FULL) begin
               mo_sh  <= {mo_sh[DATA_W-2:0], mosi};
               mo_cnt <= mo_cnt + 1'b1;
            end
            if (miso_e && mi_cnt != FULL) begin
               mi_sh  <= {mi_sh[DATA_W-2:0], miso};
               mi_cnt <= mi_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/snoop_fifo.sv
module snoop_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   output logic         full,
   input  logic         pop,
   output logic         valid,
   output logic [W-1:0] dout
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int CNT_W  = ADDR_W + 1;

   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("snoop_fifo: DEPTH must be a power of two, 2 or more");
   end

   logic [W-1:0]      mem [DEPTH];
   logic [ADDR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count;
   logic do_wr, do_rd;

   assign full  = (count == CNT_W'(DEPTH));
   assign valid = (count != '0);
   assign dout  = mem[rd_ptr];
   assign do_wr = push && !full;
   assign do_rd = pop && valid;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
      end
   end
endmodule

// File: rtl/spi_snoop_encoder.sv
module spi_snoop_encoder #(
   parameter int FIFO_DEPTH  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_i,
   input  logic       cs_n_i,
   input  logic       mosi_i,
   input  logic       miso_i,
   input  logic       cpol_i,
   input  logic       cke_i,
   input  logic       smp_i,
   input  logic       arm_i,
   input  logic [7:0] arm_cmd_i,
   input  logic       host_rx_valid_i,
   output logic       tok_valid_o,
   output logic [7:0] tok_data_o,
   input  logic       tok_ready_i,
   output logic       ovf_o
);
   import snoop_pkg::*;

   localparam int SEQ_LEN = 5;
   localparam int IDX_W   = $clog2(SEQ_LEN);

   if (FIFO_DEPTH < 8) begin : g_bad_fifo
      $error("spi_snoop_encoder: FIFO_DEPTH must hold at least one byte event");
   end

   logic [3:0] pins_s;
   logic sck_s, cs_s, mosi_s, miso_s, cs_d;
   logic cs_fall, cs_rise, arm_ok, end_req, pass;
   logic active_q;
   filt_e filt_q;
   logic cap_done;
   logic [BYTE_W-1:0] cap_mosi, cap_miso, buf_mosi, buf_miso;
   logic pend_open_q, pend_close_q, pend_byte_q, pend_ack_q;
   logic busy_q;
   logic [IDX_W-1:0] idx_q, last_q;
   logic [7:0] seq_q [SEQ_LEN];
   logic fifo_push, fifo_full;
   logic [7:0] fifo_din;
   logic ovf_q;

   snoop_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sck_i, cs_n_i, mosi_i, miso_i}),
      .q(pins_s)
   );
   assign {sck_s, cs_s, mosi_s, miso_s} = pins_s;

   assign cs_fall = ~cs_s & cs_d;
   assign cs_rise = cs_s & ~cs_d;
   assign arm_ok  = arm_i && !active_q && cmd_ok(arm_cmd_i);
   assign end_req = host_rx_valid_i && active_q;

   always_comb begin
      unique case (filt_q)
         FILT_LOW:  pass = ~cs_s;
         FILT_HIGH: pass = cs_s;
         default:   pass = 1'b1;
      endcase
   end

   snoop_capture #(.DATA_W(BYTE_W)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .clr(arm_ok | cs_fall | cs_rise),
      .en(active_q & pass),
      .sck(sck_s), .mosi(mosi_s), .miso(miso_s),
      .cpol(cpol_i), .cke(cke_i), .smp(smp_i),
      .done(cap_done), .mosi_byte(cap_mosi), .miso_byte(cap_miso)
   );

   // session state and pending events
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d         <= 1'b1;
         active_q     <= 1'b0;
         filt_q       <= FILT_ANY;
         pend_open_q  <= 1'b0;
         pend_close_q <= 1'b0;
         pend_byte_q  <= 1'b0;
         pend_ack_q   <= 1'b0;
         buf_mosi     <= '0;
         buf_miso     <= '0;
      end else begin
         cs_d <= cs_s;
         if (arm_ok) begin
            active_q <= 1'b1;
            filt_q   <= cmd_filt(arm_cmd_i);
         end else if (end_req) begin
            active_q <= 1'b0;
         end
         // the serializer takes one pending event per idle cycle
         if (!busy_q) begin
            if (pend_byte_q)       pend_byte_q  <= 1'b0;
            else if (pend_close_q) pend_close_q <= 1'b0;
            else if (pend_open_q)  pend_open_q  <= 1'b0;
            else if (pend_ack_q)   pend_ack_q   <= 1'b0;
         end
         if (active_q && cs_fall) pend_open_q  <= 1'b1;
         if (active_q && cs_rise) pend_close_q <= 1'b1;
         if (end_req)             pend_ack_q   <= 1'b1;
         if (cap_done) begin
            pend_byte_q <= 1'b1;
            buf_mosi    <= cap_mosi;
            buf_miso    <= cap_miso;
         end
      end
   end

   // token serializer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         for (int i = 0; i < SEQ_LEN; i++) seq_q[i] <= '0;
      end else if (busy_q) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == last_q) busy_q <= 1'b0;
      end else begin
         idx_q <= '0;
         if (pend_byte_q) begin
            busy_q   <= 1'b1;
            last_q   <= IDX_W'(SEQ_LEN - 1);
            seq_q[0] <= TOK_ESC;
            seq_q[1] <= buf_mosi;
            seq_q[2] <= TOK_LPAR;
            seq_q[3] <= buf_miso;
            seq_q[4] <= TOK_RPAR;
         end else if (pend_close_q || pend_open_q || pend_ack_q) begin
            busy_q   <= 1'b1;
            last_q   <= '0;
            seq_q[0] <= pend_close_q ? TOK_CLOSE : (pend_open_q ? TOK_OPEN : TOK_ACK);
         end
      end
   end

   assign fifo_push = busy_q;
   assign fifo_din  = seq_q[idx_q];

   snoop_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fifo_push), .din(fifo_din), .full(fifo_full),
      .pop(tok_ready_i), .valid(tok_valid_o), .dout(tok_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ovf_q <= 1'b0;
      else if (arm_ok)                 ovf_q <= 1'b0;
      else if (fifo_push && fifo_full) ovf_q <= 1'b1;
   end
   assign ovf_o = ovf_q;
endmodule

// File: rtl/snoop_checker.sv
module snoop_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       arm_i,
   input logic       host_rx_valid_i,
   input logic       tok_valid_o,
   input logic [7:0] tok_data_o,
   input logic       tok_ready_i,
   input logic       ovf_o,
   input logic       active_q,
   input logic       pend_ack_q,
   input logic       fifo_push,
   input logic       fifo_full
);
   assert_reset_R11: assert property (@(posedge clk)
      !rst_n |-> (!tok_valid_o && !ovf_o));

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !arm_i) |=> !active_q);

   assert_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rx_valid_i && active_q) |=> (!active_q && pend_ack_q));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid_o && !tok_ready_i) |=> (tok_valid_o && $stable(tok_data_o)));

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !arm_i) |=> ovf_o);

   assert_drop_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_push && fifo_full) |=> ovf_o);
endmodule

bind spi_snoop_encoder snoop_checker u_chk (
   .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .host_rx_valid_i(host_rx_valid_i),
   .tok_valid_o(tok_valid_o), .tok_data_o(tok_data_o), .tok_ready_i(tok_ready_i),
   .ovf_o(ovf_o), .active_q(active_q), .pend_ack_q(pend_ack_q),
   .fifo_push(fifo_push), .fifo_full(fifo_full)
);

// File: tb/sim_spi_snoop_encoder.sv
`timescale 1ns/1ps
module sim_spi_snoop_encoder;
   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso = 1'b0;
   logic cpol = 1'b0, cke = 1'b1, smp = 1'b0;
   logic arm = 1'b0, host_rx = 1'b0, ready = 1'b1;
   logic [7:0] arm_cmd = 8'h00;
   logic tok_valid, ovf;
   logic [7:0] tok_data;
   logic miso_late = 1'b0;

   int checks = 0, failures = 0;
   logic [7:0] got [64];
   int got_n = 0;
   logic [7:0] expv [64];
   int exp_n = 0;
   bit finished = 0;
   localparam int Q = 5;

   always #2 clk = ~clk;

   spi_snoop_encoder u0 (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
      .miso_i(miso), .cpol_i(cpol), .cke_i(cke), .smp_i(smp), .arm_i(arm),
      .arm_cmd_i(arm_cmd), .host_rx_valid_i(host_rx), .tok_valid_o(tok_valid),
      .tok_data_o(tok_data), .tok_ready_i(ready), .ovf_o(ovf)
   );

   always @(negedge clk) begin
      if (tok_valid && ready && got_n < 64) begin
         got[got_n] = tok_data;
         got_n++;
      end
   end

   task automatic wc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input int act, input int expd);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expd);
      end
   endtask

   task automatic add_exp(input logic [7:0] b);
      expv[exp_n] = b;
      exp_n++;
   endtask

   task automatic add_byte(input logic [7:0] mo, input logic [7:0] mi);
      add_exp(8'h5C); add_exp(mo); add_exp(8'h28); add_exp(mi); add_exp(8'h29);
   endtask

   task automatic compare(input string tag);
      wc(80);
      check(got_n == exp_n, {tag, " token count"}, got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         check(got[i] == expv[i], {tag, " token value"}, got[i], expv[i]);
      got_n = 0;
      exp_n = 0;
   endtask

   task automatic do_arm(input logic [7:0] c);
      arm_cmd = c; arm = 1'b1; wc(1); arm = 1'b0; wc(10);
   endtask

   task automatic host_byte();
      host_rx = 1'b1; wc(1); host_rx = 1'b0; wc(10);
   endtask

   task automatic set_cs(input logic v);
      cs_n = v; wc(12);
   endtask

   task automatic set_mode(input logic p, input logic e, input logic s, input logic late);
      cpol = p; cke = e; smp = s; miso_late = late; sck = p; wc(12);
   endtask

   task automatic spi_bits(input logic [7:0] mo, input logic [7:0] mi, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         if (cke) begin
            mosi = mo[i];
            if (!miso_late) miso = mi[i];
            wc(Q); sck = ~cpol;
            wc(Q); if (miso_late) miso = mi[i];
            wc(Q); sck = cpol;
            wc(Q);
         end else begin
            wc(Q); sck = ~cpol;
            wc(Q); mosi = mo[i]; miso = mi[i];
            wc(Q); sck = cpol;
            wc(Q);
         end
      end
      wc(4);
   endtask

   task automatic t_reset();
      check(tok_valid == 1'b0, "R11 valid after reset", tok_valid, 0);
      check(ovf == 1'b0, "R11 ovf after reset", ovf, 0);
   endtask

   task automatic t_bad_cmd();
      do_arm(8'h0C);
      set_cs(0); spi_bits(8'h33, 8'h44, 8); set_cs(1);
      compare("R1 unknown command");
   endtask

   task automatic t_basic();
      set_mode(0, 1, 0, 0);
      do_arm(8'h0D);
      set_cs(0); spi_bits(8'hA5, 8'h3C, 8); set_cs(1);
      add_exp(8'h5B); add_byte(8'hA5, 8'h3C); add_exp(8'h5D);
      compare("R1 R3 R4 R5 basic frame");
   endtask

   task automatic t_cpol_trail();
      set_mode(1, 0, 0, 0);
      set_cs(0); spi_bits(8'h81, 8'h7E, 8); spi_bits(8'h12, 8'hEF, 8); set_cs(1);
      add_exp(8'h5B); add_byte(8'h81, 8'h7E); add_byte(8'h12, 8'hEF); add_exp(8'h5D);
      compare("R6 idle high trailing capture");
   endtask

   task automatic t_smp_end();
      set_mode(0, 1, 1, 1);
      set_cs(0); spi_bits(8'h96, 8'h4B, 8); set_cs(1);
      add_exp(8'h5B); add_byte(8'h96, 8'h4B); add_exp(8'h5D);
      compare("R7 sample at end");
      set_mode(0, 1, 0, 0);
   endtask

   task automatic t_partial();
      set_cs(0); spi_bits(8'hFF, 8'hFF, 5); set_cs(1);
      set_cs(0); spi_bits(8'hC3, 8'h11, 8); set_cs(1);
      add_exp(8'h5B); add_exp(8'h5D); add_exp(8'h5B); add_byte(8'hC3, 8'h11); add_exp(8'h5D);
      compare("R8 partial discard");
   endtask

   task automatic t_end_ack();
      host_byte();
      add_exp(8'h01);
      compare("R9 exit ack");
   endtask

   task automatic t_filter_low();
      do_arm(8'h0E);
      spi_bits(8'h55, 8'h66, 8);
      set_cs(0); spi_bits(8'h77, 8'h88, 8); set_cs(1);
      add_exp(8'h5B); add_byte(8'h77, 8'h88); add_exp(8'h5D);
      compare("R2 filter cs low");
      t_end_ack();
   endtask

   task automatic t_filter_high();
      do_arm(8'h0F);
      spi_bits(8'h5A, 8'hA5, 8);
      set_cs(0); spi_bits(8'h99, 8'h98, 8); set_cs(1);
      add_byte(8'h5A, 8'hA5); add_exp(8'h5B); add_exp(8'h5D);
      compare("R2 R3 filter cs high");
      t_end_ack();
   endtask

   task automatic t_after_end();
      set_cs(0); spi_bits(8'hDE, 8'hAD, 8); set_cs(1);
      compare("R9 traffic after exit");
   endtask

   task automatic t_overflow();
      do_arm(8'h0D);
      ready = 1'b0;
      set_cs(0);
      for (int k = 0; k < 4; k++) spi_bits(8'h10 + 8'(k), 8'h20 + 8'(k), 8);
      set_cs(1);
      wc(40);
      check(ovf == 1'b1, "R10 overflow flag set", ovf, 1);
      check(tok_valid == 1'b1 && tok_data == 8'h5B, "R10 held head token", tok_data, 8'h5B);
      ready = 1'b1;
      wc(40);
      check(got_n == 16, "R10 drained count", got_n, 16);
      check(got[0] == 8'h5B && got[15] == 8'h29, "R10 kept oldest tokens", got[15], 8'h29);
      check(ovf == 1'b1, "R10 flag sticky after drain", ovf, 1);
      got_n = 0;
      t_end_ack();
      do_arm(8'h0D);
      check(ovf == 1'b0, "R10 flag cleared by start", ovf, 0);
      t_end_ack();
   endtask

   initial begin
      wc(5);
      rst_n = 1'b1;
      wc(5);
      t_reset();
      t_bad_cmd();
      t_basic();
      t_cpol_trail();
      t_smp_end();
      t_partial();
      t_end_ack();
      t_filter_low();
      t_filter_high();
      t_after_end();
      t_overflow();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule